// File: doc/BRIEF.md
# Load/Store Byte Alignment Datapath

This block sits between a 64-bit cache data port and the register files. It takes one access per cycle, either a load or a store, and handles all the byte steering for that access. Each access carries the low three address bits, a size code, a sign-extend flag and an endian mode. On a load, the block picks the addressed bytes out of the cache read line and right-aligns them. It then zero-pads or sign-extends the value to 64 bits. On a store, it places the right-aligned store data into the correct byte lanes of the write line and produces the matching byte-enable mask.

An access may be misaligned. If all of its bytes fall inside one aligned double-word, it finishes in one pass, with no trap and no second cycle. This holds in both endian modes. An access that runs past the end of the double-word is not serviced. It is only flagged, so that an outer sequencer can split it. Results are registered and appear exactly one cycle after the request. There is no backpressure.

Top module: `lsu_align_top`

## Requirements
- R1: While `rst_ni` is low, and in any cycle with `rsp_valid_o` low, every output is zero.
- R2: `rsp_valid_o` is high in the cycle after one in which `req_valid_i` was high, and low in the cycle after one in which it was low. All response fields describe the request of the previous cycle.
- R3: The size code 0/1/2/3 selects 1/2/4/8 bytes. When offset plus byte count exceeds 8, the access is split: `rsp_split_o` goes high, and `load_data_o`, `cache_wdata_o` and `cache_wbe_o` are all zero.
- R4: Byte lane k of the cache line is bits [8k+7:8k]. For a big-endian load of n bytes at offset o, the most significant result byte comes from lane o and the least significant from lane o+n-1.
- R5: For a little-endian load, result byte i (i=0 is least significant) comes from lane 7-o-i. The access therefore occupies lanes 8-o-n through 7-o.
- R6: For loads of fewer than 8 bytes, result bits above the loaded bytes are zero when `req_sext_i` is 0. When it is 1, they are copies of the loaded value's top bit.
- R7: A double-word load returns all 64 loaded bits in the lane order of R4/R5, and `req_sext_i` has no effect on it.
- R8: A non-split store sets exactly n bits of `cache_wbe_o`. In big-endian mode these are lanes o through o+n-1. In little-endian mode they are lanes 8-o-n through 7-o.
- R9: A non-split store writes store-data byte i (i=0 is the least significant byte of `store_data_i`) to the same lane that a load of the same size, offset and mode would read byte i from. Lanes without an enable carry zero.
- R10: A load response has `cache_wbe_o` and `cache_wdata_o` at zero, and a store response has `load_data_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_offset_i | input | 3 | Byte offset within the double-word |
| req_size_i | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 double |
| req_sext_i | input | 1 | Sign-extend the load result |
| req_le_i | input | 1 | Little-endian mode |
| cache_rdata_i | input | 64 | Cache read line for the load |
| store_data_i | input | 64 | Right-aligned store data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_split_o | output | 1 | Access crosses the double-word boundary |
| load_data_o | output | 64 | Aligned and extended load result |
| cache_wdata_o | output | 64 | Lane-placed store line |
| cache_wbe_o | output | 8 | Per-lane write enables |

## Verification
The hardest cases to reach are the misaligned accesses that end exactly on the last lane. Examples are a word at offset 4 or a half-word at offset 6. In little-endian mode these map onto lane 0 and its neighbours, and a single extra byte turns them into a split. The stimulus does not hunt for these points at random. It sweeps every size, offset, mode and extension setting, so each last-lane fit and each first overflow is driven on purpose. Random line contents give both signs of the top loaded byte. Directed cases then pin the 0x80/0x7F sign boundary and a double-word with its top bit set.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int unsigned NLANES = 8;
  localparam int unsigned BW     = 8;
  localparam int unsigned DW     = NLANES * BW;
  localparam int unsigned OFFW   = $clog2(NLANES);
  localparam int unsigned SZW    = $clog2(OFFW + 1);

  typedef enum logic [SZW-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  // lane k <-> lane NLANES-1-k
  function automatic logic [DW-1:0] byte_rev(input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int k = 0; k < int'(NLANES); k++) r[BW*k +: BW] = d[BW*(int'(NLANES)-1-k) +: BW];
    return r;
  endfunction
endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
(
  input  logic [OFFW-1:0]   offset_i,
  input  logic [SZW-1:0]    size_i,
  input  logic              le_i,
  output logic [OFFW:0]     nbytes_o,
  output logic [OFFW-1:0]   shift_o,
  output logic [NLANES-1:0] mask_o,
  output logic              split_o
);
  localparam logic [OFFW+1:0] LIMIT = (OFFW+2)'(NLANES);

  logic [OFFW:0]   nb;
  logic [OFFW+1:0] endp;
  logic [OFFW-1:0] base, lo;
  logic [NLANES:0] win;

  always_comb begin
    nb      = (OFFW+1)'(1) << size_i;
    endp    = {2'b00, offset_i} + {1'b0, nb};
    split_o = endp > LIMIT;
    // base: lane holding the least significant byte; bytes descend from it
    base    = le_i ? OFFW'(NLANES-1) - offset_i : OFFW'(endp) - OFFW'(1);
    lo      = base - OFFW'(nb) + OFFW'(1);
    win     = ((NLANES+1)'(1) << nb) - (NLANES+1)'(1);
    mask_o  = split_o ? '0 : (win[NLANES-1:0] << lo);
    shift_o = OFFW'(NLANES-1) - base;
  end

  assign nbytes_o = nb;
endmodule

// File: rtl/lsu_align_load.sv
module lsu_align_load
  import lsu_align_pkg::*;
(
  input  logic [DW-1:0]   line_i,
  input  logic [OFFW-1:0] shift_i,
  input  logic [OFFW:0]   nbytes_i,
  input  logic            sext_i,
  output logic [DW-1:0]   data_o
);
  logic [DW-1:0] rot;
  logic          sgn;
  logic          fill;

  assign rot = byte_rev(line_i) >> (BW * shift_i);

  always_comb begin
    sgn = 1'b0;
    for (int k = 1; k <= int'(NLANES); k++)
      if (int'(nbytes_i) == k) sgn = rot[BW*k-1];
  end

  assign fill = sext_i & sgn;

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    assign data_o[BW*k +: BW] = (k < int'(nbytes_i)) ? rot[BW*k +: BW] : {BW{fill}};
  end
endmodule

// File: rtl/lsu_align_store.sv
module lsu_align_store
  import lsu_align_pkg::*;
(
  input  logic [DW-1:0]     data_i,
  input  logic [OFFW-1:0]   shift_i,
  input  logic [NLANES-1:0] mask_i,
  output logic [DW-1:0]     line_o
);
  logic [DW-1:0] placed;

  assign placed = byte_rev(data_i << (BW * shift_i));

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    assign line_o[BW*k +: BW] = mask_i[k] ? placed[BW*k +: BW] : '0;
  end
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top
  import lsu_align_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [OFFW-1:0]   req_offset_i,
  input  logic [SZW-1:0]    req_size_i,
  input  logic              req_sext_i,
  input  logic              req_le_i,
  input  logic [DW-1:0]     cache_rdata_i,
  input  logic [DW-1:0]     store_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_split_o,
  output logic [DW-1:0]     load_data_o,
  output logic [DW-1:0]     cache_wdata_o,
  output logic [NLANES-1:0] cache_wbe_o
);
  logic [OFFW:0]     nbytes;
  logic [OFFW-1:0]   shift;
  logic [NLANES-1:0] mask;
  logic              split;
  logic [DW-1:0]     ld_w, st_w;

  lsu_align_ctrl u_ctrl (
    .offset_i (req_offset_i),
    .size_i   (req_size_i),
    .le_i     (req_le_i),
    .nbytes_o (nbytes),
    .shift_o  (shift),
    .mask_o   (mask),
    .split_o  (split)
  );

  lsu_align_load u_load (
    .line_i   (cache_rdata_i),
    .shift_i  (shift),
    .nbytes_i (nbytes),
    .sext_i   (req_sext_i),
    .data_o   (ld_w)
  );

  lsu_align_store u_store (
    .data_i  (store_data_i),
    .shift_i (shift),
    .mask_i  (mask),
    .line_o  (st_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_split_o   <= 1'b0;
      load_data_o   <= '0;
      cache_wdata_o <= '0;
      cache_wbe_o   <= '0;
    end else begin
      rsp_valid_o   <= req_valid_i;
      rsp_split_o   <= req_valid_i & split;
      load_data_o   <= (req_valid_i && !req_store_i && !split) ? ld_w : '0;
      cache_wdata_o <= (req_valid_i &&  req_store_i) ? st_w : '0;
      cache_wbe_o   <= (req_valid_i &&  req_store_i) ? mask : '0;
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_align_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [OFFW-1:0]   req_offset_i,
  input logic [SZW-1:0]    req_size_i,
  input logic              req_sext_i,
  input logic              req_le_i,
  input logic [DW-1:0]     cache_rdata_i,
  input logic [DW-1:0]     store_data_i,
  input logic              rsp_valid_o,
  input logic              rsp_split_o,
  input logic [DW-1:0]     load_data_o,
  input logic [DW-1:0]     cache_wdata_o,
  input logic [NLANES-1:0] cache_wbe_o
);
  logic crosses;
  assign crosses = ({1'b0, req_offset_i} + (4'd1 << req_size_i)) > 4'd8;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (cache_wbe_o == '0 && load_data_o == '0 && !rsp_split_o)); // R1
  AST_SPLIT_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && crosses) |=> rsp_split_o); // R3
  AST_SPLIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_split_o |-> (cache_wbe_o == '0 && cache_wdata_o == '0 && load_data_o == '0)); // R3
  AST_BE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && !crosses) |=>
      ($countones(cache_wbe_o) == (32'd1 << $past(req_size_i)))); // R8
  AST_DBL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i && req_size_i == SZ_DBL && req_offset_i == '0) |=>
      (load_data_o == byte_rev($past(cache_rdata_i)))); // R7
  AST_LOAD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |=> (cache_wbe_o == '0 && cache_wdata_o == '0)); // R10
  AST_STORE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i) |=> (load_data_o == '0)); // R10
endmodule

bind lsu_align_top lsu_align_chk u_chk (.*);

// File: tb/sim_lsu_align_top.sv
module sim_lsu_align_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_store_i = 1'b0;
  logic [2:0]  req_offset_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_sext_i = 1'b0;
  logic        req_le_i = 1'b0;
  logic [63:0] cache_rdata_i = '0;
  logic [63:0] store_data_i = '0;
  logic        rsp_valid_o, rsp_split_o;
  logic [63:0] load_data_o, cache_wdata_o;
  logic [7:0]  cache_wbe_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  lsu_align_top u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit st, input int off, input int sz, input bit sx, input bit le,
                       input logic [63:0] line, input logic [63:0] sd,
                       output logic [63:0] eld, output logic [63:0] ewd,
                       output logic [7:0] ebe, output bit esp);
    int n, ln;
    n = 1 << sz;
    eld = '0; ewd = '0; ebe = '0;
    esp = (off + n) > 8;
    if (esp) return;
    for (int i = 0; i < n; i++) begin
      ln = le ? 7 - off - i : off + n - 1 - i;
      if (st) begin
        ebe[ln] = 1'b1;
        ewd[8*ln +: 8] = sd[8*i +: 8];
      end else eld[8*i +: 8] = line[8*ln +: 8];
    end
    if (!st && sx && n < 8 && eld[8*n-1])
      for (int i = n; i < 8; i++) eld[8*i +: 8] = 8'hFF;
  endtask

  // drive at negedge, check at following negedge; back-to-back calls keep valid high
  task automatic access(input bit st, input int off, input int sz, input bit sx, input bit le,
                        input logic [63:0] line, input logic [63:0] sd);
    logic [63:0] eld, ewd;
    logic [7:0]  ebe;
    bit          esp;
    string       tg;
    model(st, off, sz, sx, le, line, sd, eld, ewd, ebe, esp);
    req_valid_i = 1'b1; req_store_i = st; req_offset_i = 3'(off); req_size_i = 2'(sz);
    req_sext_i = sx; req_le_i = le; cache_rdata_i = line; store_data_i = sd;
    @(negedge clk_i);
    chk("R2 valid", 64'(rsp_valid_o), 64'd1);
    chk("R3 split", 64'(rsp_split_o), 64'(esp));
    if (st) begin
      tg = esp ? "R3" : "R9";
      chk({tg, " wdata"}, cache_wdata_o, ewd);
      chk(esp ? "R3 wbe" : "R8 wbe", 64'(cache_wbe_o), 64'(ebe));
      chk("R10 load quiet", load_data_o, '0);
    end else begin
      if (esp) tg = "R3";
      else if (sz == 3) tg = "R7";
      else if (sx) tg = "R6";
      else tg = le ? "R5" : "R4";
      chk({tg, " load"}, load_data_o, eld);
      chk("R10 write quiet", {cache_wdata_o[63:8], cache_wbe_o}, '0);
    end
  endtask

  task automatic go_idle(input int cycles);
    req_valid_i = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      chk("R2 idle valid", 64'(rsp_valid_o), 64'd0);
      chk("R1 idle outputs", load_data_o | cache_wdata_o | 64'(cache_wbe_o) | 64'(rsp_split_o), '0);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b1; req_store_i = 1'b1; store_data_i = '1; cache_rdata_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", 64'(rsp_valid_o), 64'd0);
    chk("R1 reset outputs", load_data_o | cache_wdata_o | 64'(cache_wbe_o) | 64'(rsp_split_o), '0);
    req_valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_load_sweep();
    for (int le = 0; le < 2; le++)
      for (int sx = 0; sx < 2; sx++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 8; off++)
            access(1'b0, off, sz, sx[0], le[0], {$urandom, $urandom}, {$urandom, $urandom});
    go_idle(1);
  endtask

  task automatic t_store_sweep();
    for (int le = 0; le < 2; le++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 8; off++)
          access(1'b1, off, sz, 1'b0, le[0], {$urandom, $urandom}, {$urandom, $urandom});
    go_idle(2);
  endtask

  task automatic t_sign_edge();
    // R6: byte 0x80 at big-endian offset 3 extends to all ones; 0x7F stays positive
    access(1'b0, 3, 0, 1'b1, 1'b0, 64'h0000_0000_8000_0000, '0);
    chk("R6 neg byte", load_data_o, 64'hFFFF_FFFF_FFFF_FF80);
    access(1'b0, 3, 0, 1'b1, 1'b0, 64'h0000_0000_7F00_0000, '0);
    chk("R6 pos byte", load_data_o, 64'h0000_0000_0000_007F);
    // little-endian half at offset 5: lanes 2 (LSB) and 1 (MSB)
    access(1'b0, 5, 1, 1'b1, 1'b1, 64'h0000_0000_0034_9200, '0);
    chk("R5 le half sext", load_data_o, 64'hFFFF_FFFF_FFFF_9234);
    go_idle(1);
  endtask

  task automatic t_dbl_sext();
    access(1'b0, 0, 3, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, '0);
    chk("R7 dbl sext on", load_data_o, 64'hEFCD_AB89_6745_2301);
    access(1'b0, 0, 3, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, '0);
    chk("R7 dbl sext off", load_data_o, 64'hEFCD_AB89_6745_2301);
    access(1'b1, 4, 2, 1'b0, 1'b0, '0, 64'h0000_0000_A1B2_C3D4);
    chk("R8 be word off4", 64'(cache_wbe_o), 64'hF0);
    chk("R9 word off4", cache_wdata_o, 64'hD4C3_B2A1_0000_0000);
    access(1'b1, 6, 2, 1'b0, 1'b1, '0, 64'h1);
    chk("R3 le word off6 split", 64'(rsp_split_o), 64'd1);
    go_idle(1);
  endtask

  initial begin
    t_reset();
    t_load_sweep();
    t_store_sweep();
    t_sign_edge();
    t_dbl_sext();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule